// File: doc/BRIEF.md
# Thermal Bank Temperature Converter

This block turns raw thermal ADC codes from a bank of up to four sensing points into one signed temperature in millidegrees Celsius. It takes the device calibration values: gain error, a table of per-sensor offsets, calibration temperature, and a slope trim with a sign. From these it derives a fixed-point scale factor. Each sensor code is then corrected with that scale factor, clipped when it is implausibly hot, and reduced to the bank maximum.

A conversion begins with a single-cycle `start_i`. On that edge the block captures every data and calibration input. A shared restoring divider runs twice in sequence to form the scale factor. After that, one sensor is folded into the running maximum each cycle. The result is presented together with a one-cycle `done_o`. While `busy_o` is high, further start strobes are dropped.

Top module: `thermal_bank_conv`

## Requirements
- R1: After reset, `done_o` and `busy_o` are 0 and `result_o` is 32'h8000_0000, the most negative 32-bit value.
- R2: The scale factor Q is computed from the constant 1627604160 (203450520 shifted left by 3). It is divided first by (SLOPE_COEF + trim) and the quotient is then divided by (10000 + gain error). Both are truncating integer divisions.
- R3: The point value is P = (Q × (raw − offset − 3350)) >>> 3. The temperature is calibration temperature × 500 − P. All arithmetic is 32-bit two's complement, and products wrap.
- R4: When `cal_valid_i` is 0, the block uses gain error 512, offset 260 for every sensor, calibration temperature 40 and trim 0, whatever is on the calibration inputs.
- R5: The trim is −`slope_mag_i` when `slope_neg_i` is 1 and +`slope_mag_i` otherwise.
- R6: Slot i uses the offset entry selected by `sel_i[i]`. A selector of NUM_VTS or above uses the last entry.
- R7: A point temperature above 200000 is replaced by 0 before it enters the maximum.
- R8: `result_o` is the maximum over slots 0 .. N−1, where N is `num_sens_i` limited to NUM_SENS. Slots at index N and above do not affect the result. When N = 0 the result is 32'h8000_0000.
- R9: If start is accepted on an edge, `done_o` is high for exactly one cycle, and that cycle follows the edge that lies 2·DIV_W + 4 + max(N,1) edges later. `busy_o` is high from the accepting edge until the edge on which `done_o` rises.
- R10: A start while `busy_o` is high is ignored: the run in progress keeps its captured inputs and its timing. `result_o` changes only on the edge that raises `done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, taken only while idle |
| num_sens_i | input | 3 | Number of active slots |
| raw_i | input | 4×12 | Raw ADC code per slot |
| sel_i | input | 4×3 | Offset-table index per slot |
| cal_valid_i | input | 1 | Calibration inputs are valid |
| gain_err_i | input | 10 | ADC gain error |
| vts_i | input | 6×9 | Per-sensor offset table |
| degc_i | input | 6 | Calibration temperature |
| slope_mag_i | input | 6 | Slope trim magnitude |
| slope_neg_i | input | 1 | Slope trim is negative |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-cycle result strobe |
| result_o | output | 32 | Signed bank temperature, millidegrees |

## Verification
Completion and acceptance of a new start can fall in the same cycle. The block is idle again in the cycle where `done_o` is high, so a start raised in exactly that cycle must be taken. The bench raises a start in the done cycle with fresh operands. It then checks that the old result is still held one cycle later, and that the new run reports its own value after the full latency. A start raised deep inside a run is the opposite case: the bench expects the first run's value and timing, unchanged.

// File: rtl/thermal_conv_pkg.sv
package thermal_conv_pkg;
  localparam logic [31:0] SCALE_NUM   = 32'd1627604160;
  localparam int          GE_BASE     = 10000;
  localparam int          RAW_BIAS    = 3350;
  localparam int          DEGC_SCALE  = 500;
  localparam int          HOT_LIMIT   = 200000;
  localparam int          DEF_GE      = 512;
  localparam int          DEF_VTS     = 260;
  localparam int          DEF_DEGC    = 40;
  localparam logic [31:0] MIN_TEMP    = 32'h8000_0000;

  typedef enum logic [2:0] {
    ST_IDLE, ST_GO1, ST_WT1, ST_GO2, ST_WT2, ST_RED
  } conv_state_e;
endpackage

// File: rtl/thermal_divider.sv
module thermal_divider #(
  parameter int DIV_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             go_i,
  input  logic [DIV_W-1:0] dividend_i,
  input  logic [DIV_W-1:0] divisor_i,
  output logic             done_o,
  output logic [DIV_W-1:0] quo_o
);
  localparam int CNT_W = $clog2(DIV_W);

  logic             run_q;
  logic [CNT_W-1:0] cnt_q;
  logic [DIV_W:0]   rem_q;
  logic [DIV_W-1:0] quo_q, dsr_q;
  logic [DIV_W:0]   rem_sh, rem_sub;
  logic             fits;

  assign rem_sh  = {rem_q[DIV_W-1:0], quo_q[DIV_W-1]};
  assign rem_sub = rem_sh - {1'b0, dsr_q};
  assign fits    = rem_sh >= {1'b0, dsr_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      cnt_q  <= '0;
      rem_q  <= '0;
      quo_q  <= '0;
      dsr_q  <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (go_i && !run_q) begin
        run_q <= 1'b1;
        cnt_q <= '0;
        rem_q <= '0;
        quo_q <= dividend_i;
        dsr_q <= divisor_i;
      end else if (run_q) begin
        rem_q <= fits ? rem_sub : rem_sh;
        quo_q <= {quo_q[DIV_W-2:0], fits};
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == CNT_W'(DIV_W - 1)) begin
          run_q  <= 1'b0;
          done_o <= 1'b1;
        end
      end
    end
  end

  assign quo_o = quo_q;
endmodule

// File: rtl/thermal_calib_sel.sv
module thermal_calib_sel
  import thermal_conv_pkg::*;
#(
  parameter int NUM_VTS    = 6,
  parameter int VTS_W      = 9,
  parameter int GE_W       = 10,
  parameter int DEGC_W     = 6,
  parameter int SLP_W      = 6,
  parameter int SLOPE_COEF = 165
) (
  input  logic                          valid_i,
  input  logic [GE_W-1:0]               gain_err_i,
  input  logic [NUM_VTS-1:0][VTS_W-1:0] vts_i,
  input  logic [DEGC_W-1:0]             degc_i,
  input  logic [SLP_W-1:0]              slope_mag_i,
  input  logic                          slope_neg_i,
  output logic [31:0]                   div1_o,
  output logic [31:0]                   div2_o,
  output logic [NUM_VTS-1:0][VTS_W-1:0] vts_o,
  output logic [31:0]                   degc_o
);
  logic signed [31:0] trim;

  always_comb begin
    if (!valid_i)         trim = '0;
    else if (slope_neg_i) trim = -$signed({{(32-SLP_W){1'b0}}, slope_mag_i});
    else                  trim =  $signed({{(32-SLP_W){1'b0}}, slope_mag_i});
  end

  assign div1_o = 32'(SLOPE_COEF) + trim;
  assign div2_o = 32'(GE_BASE) + (valid_i ? {{(32-GE_W){1'b0}}, gain_err_i} : 32'(DEF_GE));
  assign degc_o = valid_i ? {{(32-DEGC_W){1'b0}}, degc_i} : 32'(DEF_DEGC);

  for (genvar v = 0; v < NUM_VTS; v++) begin : g_vts
    assign vts_o[v] = valid_i ? vts_i[v] : VTS_W'(DEF_VTS);
  end
endmodule

// File: rtl/thermal_point_conv.sv
module thermal_point_conv
  import thermal_conv_pkg::*;
#(
  parameter int ADC_W = 12,
  parameter int VTS_W = 9
) (
  input  logic [31:0]      scale_i,
  input  logic [ADC_W-1:0] raw_i,
  input  logic [VTS_W-1:0] vts_i,
  input  logic [31:0]      degc_i,
  output logic [31:0]      temp_o
);
  logic signed [31:0] diff, prod, shifted, base, temp;

  always_comb begin
    diff    = $signed({{(32-ADC_W){1'b0}}, raw_i}) - $signed({{(32-VTS_W){1'b0}}, vts_i})
              - 32'sd3350;
    prod    = $signed(scale_i) * diff;
    shifted = prod >>> 3;
    base    = $signed(degc_i) * 32'sd500;
    temp    = base - shifted;
    temp_o  = (temp > 32'sd200000) ? 32'd0 : temp;
  end
endmodule

// File: rtl/thermal_bank_conv.sv
module thermal_bank_conv
  import thermal_conv_pkg::*;
#(
  parameter int NUM_SENS   = 4,
  parameter int NUM_VTS    = 6,
  parameter int ADC_W      = 12,
  parameter int VTS_W      = 9,
  parameter int GE_W       = 10,
  parameter int DEGC_W     = 6,
  parameter int SLP_W      = 6,
  parameter int DIV_W      = 32,
  parameter int SLOPE_COEF = 165,
  localparam int NUM_W     = $clog2(NUM_SENS + 1),
  localparam int SEL_W     = $clog2(NUM_VTS)
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           start_i,
  input  logic [NUM_W-1:0]               num_sens_i,
  input  logic [NUM_SENS-1:0][ADC_W-1:0] raw_i,
  input  logic [NUM_SENS-1:0][SEL_W-1:0] sel_i,
  input  logic                           cal_valid_i,
  input  logic [GE_W-1:0]                gain_err_i,
  input  logic [NUM_VTS-1:0][VTS_W-1:0]  vts_i,
  input  logic [DEGC_W-1:0]              degc_i,
  input  logic [SLP_W-1:0]               slope_mag_i,
  input  logic                           slope_neg_i,
  output logic                           busy_o,
  output logic                           done_o,
  output logic [31:0]                    result_o
);
  localparam int IDX_W = $clog2(NUM_SENS + 1);

  conv_state_e                    state_q;
  logic [NUM_W-1:0]               num_q;
  logic [NUM_SENS-1:0][ADC_W-1:0] raw_q;
  logic [NUM_SENS-1:0][SEL_W-1:0] sel_q;
  logic                           cv_q, sn_q;
  logic [GE_W-1:0]                ge_q;
  logic [NUM_VTS-1:0][VTS_W-1:0]  vts_q;
  logic [DEGC_W-1:0]              degc_q;
  logic [SLP_W-1:0]               sm_q;
  logic [31:0]                    q1_q, q2_q, max_q;
  logic [IDX_W-1:0]               idx_q;

  logic [31:0]                    div1, div2, degc_eff;
  logic [NUM_VTS-1:0][VTS_W-1:0]  vts_eff;
  logic [NUM_SENS-1:0][31:0]      pt_temp;
  logic                           div_go, div_done;
  logic [DIV_W-1:0]               div_quo, div_num, div_den;
  logic [IDX_W-1:0]               n_eff;
  logic [31:0]                    cur_max, sel_temp;
  logic                           last;

  thermal_calib_sel #(
    .NUM_VTS(NUM_VTS), .VTS_W(VTS_W), .GE_W(GE_W), .DEGC_W(DEGC_W),
    .SLP_W(SLP_W), .SLOPE_COEF(SLOPE_COEF)
  ) i_calib (
    .valid_i(cv_q), .gain_err_i(ge_q), .vts_i(vts_q), .degc_i(degc_q),
    .slope_mag_i(sm_q), .slope_neg_i(sn_q),
    .div1_o(div1), .div2_o(div2), .vts_o(vts_eff), .degc_o(degc_eff)
  );

  // one divider shared by both scaling steps
  assign div_go  = (state_q == ST_GO1) || (state_q == ST_GO2);
  assign div_num = (state_q == ST_GO2) ? DIV_W'(q1_q) : DIV_W'(SCALE_NUM);
  assign div_den = (state_q == ST_GO2) ? DIV_W'(div2) : DIV_W'(div1);

  thermal_divider #(.DIV_W(DIV_W)) i_div (
    .clk_i, .rst_ni, .go_i(div_go), .dividend_i(div_num), .divisor_i(div_den),
    .done_o(div_done), .quo_o(div_quo)
  );

  for (genvar s = 0; s < NUM_SENS; s++) begin : g_pt
    logic [VTS_W-1:0] vts_pick;
    assign vts_pick = (int'(sel_q[s]) >= NUM_VTS) ? vts_eff[NUM_VTS-1] : vts_eff[sel_q[s]];
    thermal_point_conv #(.ADC_W(ADC_W), .VTS_W(VTS_W)) i_pt (
      .scale_i(q2_q), .raw_i(raw_q[s]), .vts_i(vts_pick), .degc_i(degc_eff),
      .temp_o(pt_temp[s])
    );
  end

  always_comb begin
    n_eff    = (int'(num_q) > NUM_SENS) ? IDX_W'(NUM_SENS) : IDX_W'(num_q);
    sel_temp = '0;
    for (int s = 0; s < NUM_SENS; s++) if (idx_q == IDX_W'(s)) sel_temp = pt_temp[s];
    cur_max  = max_q;
    if (idx_q < n_eff && $signed(sel_temp) > $signed(max_q)) cur_max = sel_temp;
    last     = (32'(idx_q) + 32'd1) >= 32'(n_eff);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      num_q    <= '0;
      raw_q    <= '0;
      sel_q    <= '0;
      cv_q     <= 1'b0;
      sn_q     <= 1'b0;
      ge_q     <= '0;
      vts_q    <= '0;
      degc_q   <= '0;
      sm_q     <= '0;
      q1_q     <= '0;
      q2_q     <= '0;
      max_q    <= MIN_TEMP;
      idx_q    <= '0;
      done_o   <= 1'b0;
      result_o <= MIN_TEMP;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          num_q   <= num_sens_i;
          raw_q   <= raw_i;
          sel_q   <= sel_i;
          cv_q    <= cal_valid_i;
          ge_q    <= gain_err_i;
          vts_q   <= vts_i;
          degc_q  <= degc_i;
          sm_q    <= slope_mag_i;
          sn_q    <= slope_neg_i;
          state_q <= ST_GO1;
        end
        ST_GO1: state_q <= ST_WT1;
        ST_WT1: if (div_done) begin
          q1_q    <= 32'(div_quo);
          state_q <= ST_GO2;
        end
        ST_GO2: state_q <= ST_WT2;
        ST_WT2: if (div_done) begin
          q2_q    <= 32'(div_quo);
          idx_q   <= '0;
          max_q   <= MIN_TEMP;
          state_q <= ST_RED;
        end
        ST_RED: begin
          if (last) begin
            result_o <= cur_max;
            done_o   <= 1'b1;
            state_q  <= ST_IDLE;
          end else begin
            max_q <= cur_max;
            idx_q <= idx_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o = (state_q != ST_IDLE);
endmodule

// File: rtl/thermal_bank_conv_chk.sv
module thermal_bank_conv_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        start_i,
  input logic        busy_o,
  input logic        done_o,
  input logic [31:0] result_o
);
  // R9: done is a single-cycle strobe
  a_r9_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R9: done only when the block has returned to idle
  a_r9_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  // R10: busy only begins from idle with a start
  a_r10_busy_from_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> ($past(start_i) && !$past(busy_o)));

  // R10: result holds between strobes
  a_r10_result_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(result_o));

  // R7: no delivered value exceeds the plausibility limit
  a_r7_hot_clip: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($signed(result_o) <= 32'sd200000));
endmodule

bind thermal_bank_conv thermal_bank_conv_chk i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .busy_o(busy_o),
  .done_o(done_o), .result_o(result_o)
);

// File: tb/test_thermal_bank_conv.sv
module test_thermal_bank_conv;
  localparam int NS = 4;
  localparam int NV = 6;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              start_i = 1'b0;
  logic [2:0]        num_sens_i = '0;
  logic [NS-1:0][11:0] raw_i = '0;
  logic [NS-1:0][2:0]  sel_i = '0;
  logic              cal_valid_i = 1'b0;
  logic [9:0]        gain_err_i = '0;
  logic [NV-1:0][8:0]  vts_i = '0;
  logic [5:0]        degc_i = '0;
  logic [5:0]        slope_mag_i = '0;
  logic              slope_neg_i = 1'b0;
  logic              busy_o, done_o;
  logic [31:0]       result_o;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;

  always #10 clk_i = ~clk_i;

  thermal_bank_conv i_thermal_bank_conv (.*);

  task automatic check(string req, int act, int exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int ref_bank();
    int ge, degc, tr, q, best, n, v, t, p;
    ge   = cal_valid_i ? int'(gain_err_i) : 512;
    degc = cal_valid_i ? int'(degc_i) : 40;
    tr   = !cal_valid_i ? 0 : (slope_neg_i ? -int'(slope_mag_i) : int'(slope_mag_i));
    q = 1627604160;
    q = q / (165 + tr);
    q = q / (10000 + ge);
    n = (int'(num_sens_i) > NS) ? NS : int'(num_sens_i);
    best = 32'h8000_0000;
    for (int s = 0; s < n; s++) begin
      v = !cal_valid_i ? 260 : ((int'(sel_i[s]) >= NV) ? int'(vts_i[NV-1]) : int'(vts_i[sel_i[s]]));
      p = q * (int'(raw_i[s]) - v - 3350);
      p = p >>> 3;
      t = degc * 500 - p;
      if (t > 200000) t = 0;
      if (t > best) best = t;
    end
    return best;
  endfunction

  function automatic int ref_lat();
    int n;
    n = (int'(num_sens_i) > NS) ? NS : int'(num_sens_i);
    return 69 + ((n < 1) ? 1 : n);
  endfunction

  task automatic randomize_inputs();
    num_sens_i  = 3'($urandom_range(0, 5));
    for (int s = 0; s < NS; s++) begin
      raw_i[s] = 12'($urandom);
      sel_i[s] = 3'($urandom_range(0, 7));
    end
    cal_valid_i = 1'($urandom);
    gain_err_i  = 10'($urandom);
    for (int v = 0; v < NV; v++) vts_i[v] = 9'($urandom);
    degc_i      = 6'($urandom);
    slope_mag_i = 6'($urandom);
    slope_neg_i = 1'($urandom);
  endtask

  // start already raised at the current negedge
  task automatic wait_done(output int lat);
    lat = 0;
    @(posedge clk_i); lat++;
    @(negedge clk_i); start_i = 1'b0;
    while (!done_o && lat < 400) begin
      @(posedge clk_i); lat++;
      @(negedge clk_i);
    end
  endtask

  task automatic run_check(string req);
    int lat, er, el;
    er = ref_bank(); el = ref_lat();
    @(negedge clk_i); start_i = 1'b1;
    wait_done(lat);
    check({req, " value"}, int'(result_o), er);
    check("R9 latency", lat, el);
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    int lat, ea, eb, la, lb, r0;
    void'($urandom(32'h5eed_7a11));
    repeat (3) @(negedge clk_i);
    // R1
    check("R1 done", int'(done_o), 0);
    check("R1 busy", int'(busy_o), 0);
    check("R1 result", int'(result_o), int'(32'h8000_0000));
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R4: defaults, calibration pins driven with junk
    num_sens_i = 3'd2; raw_i = {12'd0, 12'd0, 12'd3000, 12'd2600}; sel_i = '0;
    cal_valid_i = 1'b0; gain_err_i = 10'h3ff; vts_i = '1; degc_i = 6'h3f;
    slope_mag_i = 6'h3f; slope_neg_i = 1'b1;
    run_check("R4 R3 defaults");

    // R2 R3 R5: calibrated, positive and negative trim
    cal_valid_i = 1'b1; gain_err_i = 10'd300; vts_i = {9'd10, 9'd50, 9'd90, 9'd130, 9'd170, 9'd210};
    degc_i = 6'd45; slope_mag_i = 6'd20; slope_neg_i = 1'b0;
    num_sens_i = 3'd4; raw_i = {12'd3100, 12'd2900, 12'd2700, 12'd3500}; sel_i = {3'd3, 3'd2, 3'd1, 3'd0};
    run_check("R2 R5 trim+");
    slope_neg_i = 1'b1;
    run_check("R2 R5 trim-");

    // R6: out-of-range selectors use last entry
    sel_i = {3'd7, 3'd6, 3'd5, 3'd6};
    run_check("R6 sel clamp");

    // R7: very low codes give hot values that are clipped to 0
    raw_i = {12'd0, 12'd0, 12'd0, 12'd0};
    run_check("R7 clip");
    check("R7 clip zero", int'(result_o), 0);

    // R8: zero sensors -> most negative; unused slots ignored
    num_sens_i = 3'd0;
    run_check("R8 empty");
    num_sens_i = 3'd1; raw_i = {12'd4095, 12'd4095, 12'd4095, 12'd3300};
    run_check("R8 slot mask");
    num_sens_i = 3'd7;
    run_check("R8 count clamp");

    // R10: start mid-run ignored
    randomize_inputs();
    ea = ref_bank(); la = ref_lat();
    @(negedge clk_i); start_i = 1'b1;
    @(posedge clk_i); lat = 1;
    @(negedge clk_i); start_i = 1'b0;
    repeat (8) begin @(posedge clk_i); lat++; @(negedge clk_i); end
    randomize_inputs();
    start_i = 1'b1;
    @(posedge clk_i); lat++;
    @(negedge clk_i); start_i = 1'b0;
    while (!done_o && lat < 400) begin @(posedge clk_i); lat++; @(negedge clk_i); end
    check("R10 busy start value", int'(result_o), ea);
    check("R10 busy start latency", lat, la);

    // R9 R10: start in the done cycle is accepted
    randomize_inputs();
    eb = ref_bank(); lb = ref_lat();
    r0 = int'(result_o);
    start_i = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i); start_i = 1'b0;
    check("R10 hold after done", int'(result_o), r0);
    check("R9 accept in done cycle", int'(busy_o), 1);
    lat = 1;
    while (!done_o && lat < 400) begin @(posedge clk_i); lat++; @(negedge clk_i); end
    check("R9 back-to-back value", int'(result_o), eb);
    check("R9 back-to-back latency", lat, lb);

    // random sweep
    for (int k = 0; k < 60; k++) begin
      randomize_inputs();
      run_check("R3 R8 random");
    end

    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule